// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for an in-order five-stage pipeline, where each of the two ALU operands of the instruction now in execute should come from. The sources are the value read from the register file, the result held by the instruction one stage ahead (memory stage) or the result held by the instruction two stages ahead (write-back stage). It looks at the two source register indices of the execute instruction and at the destination index and register-write flag of each older in-flight instruction. It then emits one 2-bit select per operand that steers an operand multiplexer outside the block.

The unit is purely combinational: the selects follow the inputs in the same cycle, with no clock and no state. When both older stages would supply the same register, the younger producer (memory stage) wins, because its value is the more recent one. Register index zero reads as constant zero, so a write aimed at it is never bypassed. The operand multiplexers, the pipeline registers and the register file live elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a register, its destination is nonzero and equals the execute first source, `selA` is 2'b10.
- R2: When the memory-stage instruction writes a register, its destination is nonzero and equals the execute second source, `selB` is 2'b10.
- R3: When the write-back-stage instruction writes a register, its destination is nonzero and equals an operand's source, and the memory-stage condition of R1/R2 for that operand is false, that operand's select is 2'b01.
- R4: When the memory-stage and write-back-stage conditions both hold for an operand, the select is 2'b10, so the nearest producer wins.
- R5: A destination index of 0 never causes a bypass from either stage, whatever the write flag and source indices are.
- R6: A stage whose register-write flag is 0 never causes a bypass, even when its destination matches.
- R7: When no bypass condition holds, the select is 2'b00 (register file). The code 2'b11 is never produced.
- R8: The selects depend only on the present inputs, with no latency: a change at the inputs shows at the outputs before the next clock edge of the surrounding pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exSrcA | input | 5 | First source register index of the execute-stage instruction |
| exSrcB | input | 5 | Second source register index of the execute-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| memDst | input | 5 | Destination register index of the memory-stage instruction |
| wbWrEn | input | 1 | Write-back-stage instruction writes a register |
| wbDst | input | 5 | Destination register index of the write-back-stage instruction |
| selA | output | 2 | First operand source: 00 register file, 10 memory stage, 01 write-back stage |
| selB | output | 2 | Second operand source, same coding as selA |

## Verification
The bench runs a chain of three consecutive writes to one register. A design that let the older write-back result win would return 2'b01 where the nearest producer demands 2'b10. It also targets writes to register zero and matching destinations whose write flag is low. A unit that skipped either guard would forward a value that must never be seen. Both operands are driven to the same and to different producers at once to expose an operand crosswiring, and a long pseudo-random stream over a handful of register indices packs hazards densely enough to hit every combination of stage matches.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int SRC_CNT = 2;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } opnd_sel_e;

  // strobes passed from the match datapath to the select control
  typedef struct packed {
    logic [SRC_CNT-1:0] memHit;
    logic [SRC_CNT-1:0] wbHit;
  } hit_strobe_t;
endpackage

// File: rtl/fwd_match_dp.sv
module fwd_match_dp
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [SRC_CNT-1:0][IDX_W-1:0] srcIdx,
  input  logic                          memWrEn,
  input  logic [IDX_W-1:0]              memDst,
  input  logic                          wbWrEn,
  input  logic [IDX_W-1:0]              wbDst,
  output hit_strobe_t                   hits
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic memLive;
  logic wbLive;

  // a producer is live only if it writes and does not target the zero register
  always_comb begin
    memLive = memWrEn && (memDst != ZERO_IDX);
    wbLive  = wbWrEn  && (wbDst  != ZERO_IDX);
  end

  for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
    always_comb begin
      hits.memHit[s] = memLive && (memDst == srcIdx[s]);
      hits.wbHit[s]  = wbLive  && (wbDst  == srcIdx[s]);
    end
  end
endmodule

// File: rtl/fwd_select_ctrl.sv
module fwd_select_ctrl
  import fwd_pkg::*;
(
  input  hit_strobe_t                   hits,
  output logic [SRC_CNT-1:0][SEL_W-1:0] sel
);
  for (genvar s = 0; s < SRC_CNT; s++) begin : g_sel
    always_comb begin
      // younger producer first
      if (hits.memHit[s])     sel[s] = SEL_MEM;
      else if (hits.wbHit[s]) sel[s] = SEL_WB;
      else                    sel[s] = SEL_REGFILE;
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] exSrcA,
  input  logic [IDX_W-1:0] exSrcB,
  input  logic             memWrEn,
  input  logic [IDX_W-1:0] memDst,
  input  logic             wbWrEn,
  input  logic [IDX_W-1:0] wbDst,
  output logic [1:0]       selA,
  output logic [1:0]       selB
);
  logic [SRC_CNT-1:0][IDX_W-1:0] srcIdx;
  logic [SRC_CNT-1:0][SEL_W-1:0] sel;
  hit_strobe_t                   hits;

  assign srcIdx[0] = exSrcA;
  assign srcIdx[1] = exSrcB;

  fwd_match_dp #(.IDX_W(IDX_W)) match_i (
    .srcIdx (srcIdx),
    .memWrEn(memWrEn),
    .memDst (memDst),
    .wbWrEn (wbWrEn),
    .wbDst  (wbDst),
    .hits   (hits)
  );

  fwd_select_ctrl ctrl_i (
    .hits(hits),
    .sel (sel)
  );

  assign selA = sel[0];
  assign selB = sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] exSrcA,
  input logic [IDX_W-1:0] exSrcB,
  input logic             memWrEn,
  input logic [IDX_W-1:0] memDst,
  input logic             wbWrEn,
  input logic [IDX_W-1:0] wbDst,
  input logic [1:0]       selA,
  input logic [1:0]       selB
);
  always_comb begin
    // R7: code 11 is illegal on both outputs
    p_no_code3_r7: assert (selA != 2'b11 && selB != 2'b11);
    // R1 / R4: memory producer on operand A always selected
    if (memWrEn && memDst != '0 && memDst == exSrcA)
      p_mem_a_r1: assert (selA == 2'b10);
    // R2 / R4: memory producer on operand B always selected
    if (memWrEn && memDst != '0 && memDst == exSrcB)
      p_mem_b_r2: assert (selB == 2'b10);
    // R6: no write flags, no bypass
    if (!memWrEn && !wbWrEn)
      p_no_wr_r6: assert (selA == 2'b00 && selB == 2'b00);
    // R5: both destinations are the zero register
    if (memDst == '0 && wbDst == '0)
      p_zero_dst_r5: assert (selA == 2'b00 && selB == 2'b00);
    // R3: write-back code only with a live write-back match
    if (selA == 2'b01)
      p_wb_a_r3: assert (wbWrEn && wbDst == exSrcA && wbDst != '0);
  end
endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  localparam int W = 5;

  typedef struct {
    bit       wr;
    bit [4:0] rd;
    bit [4:0] rs;
    bit [4:0] rt;
  } instr_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] exSrcA = '0, exSrcB = '0, memDst = '0, wbDst = '0;
  logic         memWrEn = 1'b0, wbWrEn = 1'b0;
  logic [1:0]   selA, selB;

  fwd_unit dut_i (
    .exSrcA(exSrcA), .exSrcB(exSrcB),
    .memWrEn(memWrEn), .memDst(memDst),
    .wbWrEn(wbWrEn), .wbDst(wbDst),
    .selA(selA), .selB(selB)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  instr_t prog[$];
  instr_t pipe[$];  // [0]=execute, [1]=memory, [2]=write-back

  task automatic addI(bit wr, int rd, int rs, int rt);
    instr_t i;
    i.wr = wr; i.rd = 5'(rd); i.rs = 5'(rs); i.rt = 5'(rt);
    prog.push_back(i);
  endtask

  // behavioural reference: walk older instructions nearest first
  task automatic refSel(input bit [4:0] src, output bit [1:0] code, output string tag);
    bit shadowed = 0;
    code = 2'b00; tag = "R7";
    for (int k = 1; k <= 2; k++) begin
      if (pipe.size() > k && pipe[k].rd == src) begin
        if (!pipe[k].wr) begin if (tag == "R7") tag = "R6"; end
        else if (src == 0) begin if (tag == "R7") tag = "R5"; end
        else if (code == 2'b00) begin
          code = (k == 1) ? 2'b10 : 2'b01;
          tag  = (k == 1) ? "R1" : (shadowed ? "R4" : "R3");
        end else tag = "R4";
        if (k == 1 && pipe[k].wr && src != 0) shadowed = 1;
      end
    end
  endtask

  task automatic check(string tag, string opnd, logic [1:0] act, bit [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op%s: actual=%b expected=%b", tag, opnd, act, exp);
    end
  endtask

  task automatic stepAndCheck();
    bit [1:0] ea, eb;
    string ta, tb;
    @(posedge clk); #1;
    exSrcA  = pipe[0].rs; exSrcB = pipe[0].rt;
    memWrEn = (pipe.size() > 1) ? pipe[1].wr : 1'b0;
    memDst  = (pipe.size() > 1) ? pipe[1].rd : 5'd0;
    wbWrEn  = (pipe.size() > 2) ? pipe[2].wr : 1'b0;
    wbDst   = (pipe.size() > 2) ? pipe[2].rd : 5'd0;
    // R8: outputs checked within the same cycle the inputs change
    @(negedge clk);
    refSel(pipe[0].rs, ea, ta);
    refSel(pipe[0].rt, eb, tb);
    if (tb == "R1") tb = "R2";
    check(ta, "A", selA, ea);
    check(tb, "B", selB, eb);
  endtask

  initial begin
    int seed = 17;
    // reset state: all inputs zero gives register-file selects (R7)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", "A", selA, 2'b00);
    check("R7", "B", selB, 2'b00);
    rst = 1'b0;

    // R4 chain: three writes to r1, each reading r1
    addI(1, 1, 1, 2); addI(1, 1, 1, 3); addI(1, 1, 1, 4); addI(1, 5, 1, 1);
    // R1/R2 distinct producers on both operands
    addI(1, 6, 0, 0); addI(1, 7, 0, 0); addI(1, 8, 7, 6);
    // R5: writes to register zero, then consumer of r0
    addI(1, 0, 0, 0); addI(1, 0, 0, 0); addI(1, 9, 0, 0);
    // R6: non-writing producers naming r10
    addI(0, 10, 0, 0); addI(0, 10, 0, 0); addI(1, 11, 10, 10);
    // R3 only: producer two back
    addI(1, 12, 0, 0); addI(1, 13, 0, 0); addI(1, 14, 12, 3);
    // R7: no dependence at all
    addI(1, 15, 0, 0); addI(1, 16, 0, 0); addI(1, 17, 20, 21);
    // dense pseudo-random stream on registers 0..3
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      addI((seed >>> 16) & 1, (seed >>> 17) & 3, (seed >>> 19) & 3, (seed >>> 21) & 3);
    end

    while (prog.size() > 0) begin
      pipe.push_front(prog.pop_front());
      if (pipe.size() > 3) void'(pipe.pop_back());
      stepAndCheck();
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule